// File: doc/BRIEF.md
# Dual-Rate CAN Bit Timing Generator

This block produces the time base for a CAN node whose frames run at a nominal rate during arbitration and may switch to a faster rate for the data field. It divides the CAN clock into time quanta and arranges them into bits. Each bit has a one-quantum sync segment, a first phase segment that ends at the sample point, and a second phase segment that ends the bit. For every bit it marks the sample point and the end of the bit. A surrounding protocol engine uses these strobes to sample and drive the bus.

Two independent timing sets are held on input ports, one nominal and one for the data phase. The data set has narrower segment fields. Every field is written as its real value minus one. A select input picks the set, and the choice only takes hold at a bit boundary. A falling edge on the receive line is a recessive-to-dominant transition. When one arrives outside the sync segment, the generator resynchronizes. It lengthens the first phase segment or shortens the second, by no more than the jump width. The timing fields are expected to change only while `enable` is low.

Top module: `can_bittime_gen`

## Requirements
- R1: While `enable` is low, `tq_tick`, `sample_pt` and `bit_end` stay low, and from the following cycle `fast_active` is 0. After reset all four outputs are 0.
- R2: With prescaler field P for the active set, `tq_tick` is high in every (P+1)-th enabled cycle. The first tick of a bit comes P+1 cycles after the bit starts. A prescaler field of 0 gives a tick in every cycle.
- R3: A bit with no resynchronization lasts 1 + (A+1) + (B+1) quanta, where A and B are the phase-1 and phase-2 fields of the active set. `bit_end` is high together with the tick that closes the last quantum.
- R4: `sample_pt` is high together with the tick that closes quantum A+1 of the bit, counting the sync quantum as quantum 0. It is never high in the same cycle as `bit_end`, and it occurs once in each bit, before `bit_end`.
- R5: `fast_sel` (1 = data set, 0 = nominal set) is taken only in a `bit_end` cycle, and it governs the next bit. `fast_active` shows the set in use. The first bit after `enable` rises always uses the nominal set.
- R6: The jump width is J = jump field + 1. A falling edge on `rx` during quantum q of phase 1 (1 ≤ q) extends phase 1 by min(q, J) quanta, which moves both the sample point and the bit end later.
- R7: A falling edge on `rx` during quantum c of phase 2 (c counted from 1) first computes the remaining quanta r = (B+1) − c. If r ≤ J, the bit ends with the tick that closes quantum c. Otherwise phase 2 is shortened by J quanta.
- R8: The following have no effect on the strobes: a falling edge during the sync quantum, any rising edge, and a second falling edge after a resynchronization in the same bit.
- R9: Dropping `enable` in the middle of a bit abandons that bit. On the next rise of `enable`, a fresh nominal bit starts with the prescaler count at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CAN clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Runs the generator; low holds it idle |
| fast_sel | input | 1 | Requests the data-phase set for the next bit |
| nom_presc | input | 8 | Nominal prescaler, value minus one |
| nom_ph1 | input | 6 | Nominal propagation plus phase-1 length, minus one |
| nom_ph2 | input | 4 | Nominal phase-2 length, minus one |
| nom_jump | input | 4 | Nominal jump width, minus one |
| dat_presc | input | 8 | Data-phase prescaler, value minus one |
| dat_ph1 | input | 4 | Data-phase phase-1 length, minus one |
| dat_ph2 | input | 3 | Data-phase phase-2 length, minus one |
| dat_jump | input | 3 | Data-phase jump width, minus one |
| rx | input | 1 | Receive line, 1 = recessive |
| tq_tick | output | 1 | One-cycle pulse closing each time quantum |
| sample_pt | output | 1 | One-cycle pulse at the sample point |
| bit_end | output | 1 | One-cycle pulse closing each bit |
| fast_active | output | 1 | The current bit uses the data-phase set |

## Verification
The bit timing is driven with a quiet receive line at three settings: a mid-range nominal setting with a prescaler above one, all fields at zero, and the phase-1 and phase-2 fields at their maximum. Comparing these shows whether the segment arithmetic and the value-plus-one decoding hold at both ends of the field ranges.

A run alternates between the two sets, with the select changed in the middle of a bit. This shows whether the switch waits for the bit boundary, and whether the data set's prescaler and segments are really used.

Falling edges are placed at chosen quanta. Edges early in phase 1 and at its cap test lengthening. Edges in phase 2 test both shortening branches. Edges in the sync quantum, and a second edge in the same bit, must leave the timing unchanged. A disable in the middle of a bit confirms the restart state.

// File: rtl/can_bt_pkg.sv
package can_bt_pkg;
  typedef enum logic [1:0] {
    SEG_SYNC = 2'd0,
    SEG_PH1  = 2'd1,
    SEG_PH2  = 2'd2
  } seg_st_t;
endpackage

// File: rtl/can_bt_prescale.sv
module can_bt_prescale #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [W-1:0] div_m1,
  output logic         tick
);
  logic [W-1:0] cnt_q, cnt_d;

  assign tick = en && (cnt_q >= div_m1);

  always_comb begin
    cnt_d = cnt_q;
    if (!en)       cnt_d = '0;
    else if (tick) cnt_d = '0;
    else           cnt_d = cnt_q + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/can_bt_rxedge.sv
module can_bt_rxedge #(
  parameter int STAGES = 0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic rx,
  output logic fall
);
  logic rx_s;
  logic prev_q;

  generate
    if (STAGES == 0) begin : g_direct
      assign rx_s = rx;
    end else begin : g_sync
      logic [STAGES-1:0] sh_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '1;
        else begin
          sh_q[0] <= rx;
          for (int i = 1; i < STAGES; i++) sh_q[i] <= sh_q[i-1];
        end
      end
      assign rx_s = sh_q[STAGES-1];
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b1;
    else        prev_q <= rx_s;
  end

  assign fall = en && prev_q && !rx_s;
endmodule

// File: rtl/can_bt_seqr.sv
module can_bt_seqr import can_bt_pkg::*; #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          tick,
  input  logic          fall,
  input  logic [CW-1:0] ph1_len,
  input  logic [CW-1:0] ph2_len,
  input  logic [CW-1:0] jump_len,
  output logic          sample_pt,
  output logic          bit_end
);
  seg_st_t       st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [CW-1:0] l1_q, l1_d;
  logic [CW-1:0] l2_q, l2_d;
  logic          used_q, used_d;

  logic          edge_ok;
  logic [CW-1:0] late_ext;
  logic [CW-1:0] rem2;
  logic [CW-1:0] l1_eff;
  logic [CW-1:0] l2_eff;

  // limits as seen this cycle, including a resync edge arriving now
  always_comb begin
    edge_ok  = fall && !used_q && (st_q != SEG_SYNC);
    late_ext = (cnt_q < jump_len) ? cnt_q : jump_len;
    rem2     = l2_q - cnt_q;
    l1_eff   = l1_q;
    l2_eff   = l2_q;
    if (edge_ok && (st_q == SEG_PH1)) l1_eff = l1_q + late_ext;
    if (edge_ok && (st_q == SEG_PH2)) l2_eff = (rem2 <= jump_len) ? cnt_q : (l2_q - jump_len);
  end

  assign sample_pt = en && tick && (st_q == SEG_PH1) && (cnt_q == l1_eff);
  assign bit_end   = en && tick && (st_q == SEG_PH2) && (cnt_q == l2_eff);

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    l1_d   = l1_q;
    l2_d   = l2_q;
    used_d = used_q;
    if (!en) begin
      st_d   = SEG_SYNC;
      cnt_d  = '0;
      used_d = 1'b0;
    end else begin
      if (edge_ok) begin
        used_d = 1'b1;
        l1_d   = l1_eff;
        l2_d   = l2_eff;
      end
      if (tick) begin
        unique case (st_q)
          SEG_SYNC: begin
            st_d  = SEG_PH1;
            cnt_d = CW'(1);
            l1_d  = ph1_len;
            l2_d  = ph2_len;
          end
          SEG_PH1: begin
            if (cnt_q == l1_eff) begin
              st_d  = SEG_PH2;
              cnt_d = CW'(1);
            end else begin
              cnt_d = cnt_q + CW'(1);
            end
          end
          SEG_PH2: begin
            if (cnt_q == l2_eff) begin
              st_d   = SEG_SYNC;
              cnt_d  = '0;
              used_d = 1'b0;
            end else begin
              cnt_d = cnt_q + CW'(1);
            end
          end
          default: begin
            st_d  = SEG_SYNC;
            cnt_d = '0;
          end
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SEG_SYNC;
      cnt_q  <= '0;
      l1_q   <= '0;
      l2_q   <= '0;
      used_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      l1_q   <= l1_d;
      l2_q   <= l2_d;
      used_q <= used_d;
    end
  end
endmodule

// File: rtl/can_bittime_gen.sv
module can_bittime_gen #(
  parameter int NPRE_W  = 8,
  parameter int NPH1_W  = 6,
  parameter int NPH2_W  = 4,
  parameter int NJMP_W  = 4,
  parameter int DPRE_W  = 8,
  parameter int DPH1_W  = 4,
  parameter int DPH2_W  = 3,
  parameter int DJMP_W  = 3,
  parameter int RX_SYNC = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              fast_sel,
  input  logic [NPRE_W-1:0] nom_presc,
  input  logic [NPH1_W-1:0] nom_ph1,
  input  logic [NPH2_W-1:0] nom_ph2,
  input  logic [NJMP_W-1:0] nom_jump,
  input  logic [DPRE_W-1:0] dat_presc,
  input  logic [DPH1_W-1:0] dat_ph1,
  input  logic [DPH2_W-1:0] dat_ph2,
  input  logic [DJMP_W-1:0] dat_jump,
  input  logic              rx,
  output logic              tq_tick,
  output logic              sample_pt,
  output logic              bit_end,
  output logic              fast_active
);
  localparam int PRE_W = (NPRE_W > DPRE_W) ? NPRE_W : DPRE_W;
  localparam int PH1_W = (NPH1_W > DPH1_W) ? NPH1_W : DPH1_W;
  localparam int CW    = PH1_W + 2;

  logic             fast_q, fast_d;
  logic [PRE_W-1:0] cur_presc;
  logic [CW-1:0]    cur_ph1, cur_ph2, cur_jump;
  logic             fall;

  always_comb begin
    if (fast_q) begin
      cur_presc = PRE_W'(dat_presc);
      cur_ph1   = CW'(dat_ph1)  + CW'(1);
      cur_ph2   = CW'(dat_ph2)  + CW'(1);
      cur_jump  = CW'(dat_jump) + CW'(1);
    end else begin
      cur_presc = PRE_W'(nom_presc);
      cur_ph1   = CW'(nom_ph1)  + CW'(1);
      cur_ph2   = CW'(nom_ph2)  + CW'(1);
      cur_jump  = CW'(nom_jump) + CW'(1);
    end
  end

  always_comb begin
    fast_d = fast_q;
    if (!enable)      fast_d = 1'b0;
    else if (bit_end) fast_d = fast_sel;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fast_q <= 1'b0;
    else        fast_q <= fast_d;
  end

  assign fast_active = fast_q;

  can_bt_prescale #(.W(PRE_W)) u_presc (
    .clk    (clk),
    .rst_n  (rst_n),
    .en     (enable),
    .div_m1 (cur_presc),
    .tick   (tq_tick)
  );

  can_bt_rxedge #(.STAGES(RX_SYNC)) u_edge (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (enable),
    .rx    (rx),
    .fall  (fall)
  );

  can_bt_seqr #(.CW(CW)) u_seqr (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (enable),
    .tick      (tq_tick),
    .fall      (fall),
    .ph1_len   (cur_ph1),
    .ph2_len   (cur_ph2),
    .jump_len  (cur_jump),
    .sample_pt (sample_pt),
    .bit_end   (bit_end)
  );
endmodule

// File: rtl/can_bittime_gen_chk.sv
module can_bittime_gen_chk (
  input logic clk,
  input logic rst_n,
  input logic enable,
  input logic tq_tick,
  input logic sample_pt,
  input logic bit_end,
  input logic fast_active
);
  logic saw_sp_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   saw_sp_q <= 1'b0;
    else if (!enable || bit_end)  saw_sp_q <= 1'b0;
    else if (sample_pt)           saw_sp_q <= 1'b1;
  end

  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |-> (!tq_tick && !sample_pt && !bit_end));

  a_r1_idle_nominal: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !fast_active);

  a_r3_end_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    bit_end |-> tq_tick);

  a_r4_sample_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    sample_pt |-> (tq_tick && !bit_end));

  a_r4_sample_before_end: assert property (@(posedge clk) disable iff (!rst_n)
    bit_end |-> saw_sp_q);

  a_r5_set_held: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !bit_end) |=> $stable(fast_active));
endmodule

bind can_bittime_gen can_bittime_gen_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .enable      (enable),
  .tq_tick     (tq_tick),
  .sample_pt   (sample_pt),
  .bit_end     (bit_end),
  .fast_active (fast_active)
);

// File: tb/can_bittime_gen_test.sv
`timescale 1ns/1ps
module can_bittime_gen_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enable = 1'b0;
  logic fast_sel = 1'b0;
  logic rx = 1'b1;
  logic [7:0] nom_presc = '0;
  logic [5:0] nom_ph1 = '0;
  logic [3:0] nom_ph2 = '0;
  logic [3:0] nom_jump = '0;
  logic [7:0] dat_presc = '0;
  logic [3:0] dat_ph1 = '0;
  logic [2:0] dat_ph2 = '0;
  logic [2:0] dat_jump = '0;
  logic tq_tick, sample_pt, bit_end, fast_active;

  always #2.5 clk = ~clk;

  can_bittime_gen uut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .fast_sel(fast_sel),
    .nom_presc(nom_presc), .nom_ph1(nom_ph1), .nom_ph2(nom_ph2), .nom_jump(nom_jump),
    .dat_presc(dat_presc), .dat_ph1(dat_ph1), .dat_ph2(dat_ph2), .dat_jump(dat_jump),
    .rx(rx), .tq_tick(tq_tick), .sample_pt(sample_pt), .bit_end(bit_end),
    .fast_active(fast_active)
  );

  typedef struct {
    int    cyc;
    bit    is_end;
    bit    fast;
    string tag;
  } exp_ev_t;

  exp_ev_t sb_q[$];
  int cyc = 0;
  int cb = 0;
  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;
  bit tick_log [0:1023];

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // monitor: compares strobes against the scoreboard away from the edge
  always @(negedge clk) begin
    if (!enable) begin
      cyc = 0;
    end else begin
      if (cyc < 1024) tick_log[cyc] = tq_tick;
      if (sample_pt || bit_end) begin
        if (sb_q.size() == 0) begin
          chk(1'b0, "R3", "unexpected strobe at cycle", cyc, -1);
        end else begin
          exp_ev_t e;
          e = sb_q.pop_front();
          chk((e.cyc == cyc) && (bit_end == e.is_end) && (sample_pt == !e.is_end)
              && (fast_active == e.fast),
              e.tag, e.is_end ? "bit end cycle" : "sample cycle", cyc, e.cyc);
        end
      end
      cyc = cyc + 1;
    end
  end

  // driver side: push expected strobes for one bit
  task automatic push_bit(input int p, input int s1, input int s2, input int ext,
                          input int len_ovr, input bit fast, input string tag);
    exp_ev_t e;
    int len;
    len = (len_ovr > 0) ? len_ovr : (1 + s1 + s2 + ext);
    e.cyc = cb + (1 + s1 + ext) * p - 1; e.is_end = 1'b0; e.fast = fast; e.tag = tag;
    sb_q.push_back(e);
    e.cyc = cb + len * p - 1; e.is_end = 1'b1;
    sb_q.push_back(e);
    cb = cb + len * p;
  endtask

  task automatic set_nom(input int p, input int a, input int b, input int j);
    nom_presc = 8'(p); nom_ph1 = 6'(a); nom_ph2 = 4'(b); nom_jump = 4'(j);
  endtask

  task automatic set_dat(input int p, input int a, input int b, input int j);
    dat_presc = 8'(p); dat_ph1 = 4'(a); dat_ph2 = 3'(b); dat_jump = 3'(j);
  endtask

  task automatic go();
    @(posedge clk); #1;
    enable = 1'b1;
  endtask

  task automatic at_cycle(input int c);
    while (cyc != c) @(posedge clk);
    #1;
  endtask

  task automatic edge_at(input int c);
    at_cycle(c);     rx = 1'b0;
    at_cycle(c + 1); rx = 1'b1;
  endtask

  task automatic finish_scn(input string tag);
    int guard = 0;
    while (sb_q.size() != 0 && guard < 2000) begin
      @(negedge clk);
      guard++;
    end
    chk(sb_q.size() == 0, tag, "expected strobes never seen", sb_q.size(), 0);
    sb_q.delete();
    @(posedge clk); #1;
    enable = 1'b0; fast_sel = 1'b0; rx = 1'b1;
    repeat (2) @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_chk + 1, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1: idle after reset
    chk(!tq_tick && !sample_pt && !bit_end, "R1", "strobes after reset",
        int'(tq_tick) + int'(sample_pt) + int'(bit_end), 0);
    chk(!fast_active, "R1", "fast_active after reset", int'(fast_active), 0);

    // R2 R3 R4: prescaler 1, phase1 5 quanta, phase2 3 quanta
    set_nom(1, 4, 2, 0); set_dat(0, 0, 0, 0);
    cb = 0;
    for (int k = 0; k < 3; k++) push_bit(2, 5, 3, 0, 0, 1'b0, "R3");
    go();
    finish_scn("R3");
    chk(!tick_log[0], "R2", "tick at cycle 0", int'(tick_log[0]), 0);
    chk(tick_log[1],  "R2", "tick at cycle 1", int'(tick_log[1]), 1);
    chk(!tick_log[2], "R2", "tick at cycle 2", int'(tick_log[2]), 0);
    chk(tick_log[3],  "R2", "tick at cycle 3", int'(tick_log[3]), 1);

    // R2 R4 boundary: all fields zero, three-quantum bits
    set_nom(0, 0, 0, 0);
    cb = 0;
    for (int k = 0; k < 3; k++) push_bit(1, 1, 1, 0, 0, 1'b0, "R4");
    go();
    finish_scn("R4");
    chk(tick_log[0] && tick_log[1], "R2", "tick every cycle at zero prescaler",
        int'(tick_log[0]) + int'(tick_log[1]), 2);

    // R3 boundary: maximum phase fields, 81-quantum bits
    set_nom(0, 63, 15, 0);
    cb = 0;
    for (int k = 0; k < 2; k++) push_bit(1, 64, 16, 0, 0, 1'b0, "R3");
    go();
    finish_scn("R3");

    // R5: switch sets mid-bit, effective at the next boundary
    set_nom(2, 5, 3, 0); set_dat(0, 2, 1, 0);
    cb = 0;
    push_bit(3, 6, 4, 0, 0, 1'b0, "R5");
    push_bit(1, 3, 2, 0, 0, 1'b1, "R5");
    push_bit(1, 3, 2, 0, 0, 1'b1, "R5");
    push_bit(3, 6, 4, 0, 0, 1'b0, "R5");
    go();
    at_cycle(5);  fast_sel = 1'b1;
    at_cycle(40); fast_sel = 1'b0;
    finish_scn("R5");
    chk(!tick_log[30], "R2", "nominal tick gap in data switch run", int'(tick_log[30]), 0);
    chk(tick_log[34] && tick_log[35], "R2", "data-set tick each cycle",
        int'(tick_log[34]) + int'(tick_log[35]), 2);

    // R6: late edges in phase 1, jump width 2
    set_nom(1, 4, 2, 1);
    cb = 0;
    push_bit(2, 5, 3, 1, 0, 1'b0, "R6");
    push_bit(2, 5, 3, 2, 0, 1'b0, "R6");
    push_bit(2, 5, 3, 0, 0, 1'b0, "R6");
    go();
    edge_at(2);
    edge_at(28);
    finish_scn("R6");

    // R7: early edges in phase 2, both branches
    set_nom(0, 3, 5, 1);
    cb = 0;
    push_bit(1, 4, 6, 0, 9, 1'b0, "R7");
    push_bit(1, 4, 6, 0, 10, 1'b0, "R7");
    push_bit(1, 4, 6, 0, 0, 1'b0, "R7");
    go();
    edge_at(6);
    edge_at(18);
    finish_scn("R7");

    // R8: sync-quantum edge, rising edge and second edge ignored
    cb = 0;
    push_bit(1, 4, 6, 0, 0, 1'b0, "R8");
    push_bit(1, 4, 6, 0, 0, 1'b0, "R8");
    push_bit(1, 4, 6, 1, 0, 1'b0, "R8");
    go();
    edge_at(11);
    edge_at(23);
    edge_at(25);
    finish_scn("R8");

    // R9: abandon a bit, restart fresh and nominal
    set_nom(1, 4, 2, 0); set_dat(0, 2, 1, 0);
    cb = 0;
    go();
    at_cycle(7);
    enable = 1'b0;
    @(negedge clk);
    chk(!tq_tick && !sample_pt && !bit_end, "R1", "strobes while disabled",
        int'(tq_tick) + int'(sample_pt) + int'(bit_end), 0);
    @(negedge clk);
    chk(!fast_active, "R1", "fast_active while disabled", int'(fast_active), 0);
    cb = 0;
    push_bit(2, 5, 3, 0, 0, 1'b0, "R9");
    push_bit(1, 3, 2, 0, 0, 1'b1, "R9");
    fast_sel = 1'b1;
    go();
    finish_scn("R9");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule